// File: doc/BRIEF.md
# Memory Port Bus Slave Front End

This block terminates one AHB-Lite slave port of a multi-port external memory controller. It watches the address phase of the bus. It qualifies each transfer with a global select line and an eight-line one-hot chip-select vector, and it checks the transfer size and type. It then produces the bus response signals: ready, response code and read data. A legal NONSEQ or SEQ transfer becomes one request on an internal valid/ready channel toward the memory back end. The request carries the chip-select index, the address, the size, the direction, the burst code, the lock flag and the write data. The back end answers a read with a one-cycle response pulse that carries the data.

Illegal transfers never reach the back end. These are sizes wider than 32 bits, several chip-select lines active at once, and the global select with no chip-select line. They are answered with a two-cycle ERROR. Only the OKAY and ERROR response codes are ever driven. A master lock request is passed on to the arbiter as a level, so that other ports stay held off while the lock is active. A port whose inputs are all tied low stays idle for good.

Back-pressure rules on the request channel: once `req_valid` rises, it and every payload field stay unchanged until the cycle in which `req_ready` is high. The transfer is taken in that cycle. `rsp_valid` needs no ready signal. It is looked at only while a read is waiting for data, and it is ignored at any other time.

Top module: `mem_port_front`

## Requirements
- R1: After reset, `hready_out` is 1, `hresp` is OKAY (00), `req_valid` is 0, `lock_out` is 0 and `hrdata` is 0.
- R2: A transfer is sampled at a clock edge only when `hsel_glb`, `hready_in` and `hready_out` are all 1. A sampled IDLE (00) or BUSY (01) transfer gets a zero-wait OKAY and creates no request.
- R3: A sampled NONSEQ (10) or SEQ (11) transfer is accepted when exactly one `hsel_cs` bit is set and `hsize` is byte (000), halfword (001) or word (010). In the next cycle `req_valid` is 1 and `hready_out` is 0. The request carries the index of the set chip-select bit plus the address, size, direction, burst code and lock value from the address phase.
- R4: While `req_valid` is 1 and `req_ready` is 0, `req_valid` and all request fields hold. `req_wdata` follows `hwdata` while `req_valid` is 1.
- R5: A write completes in the cycle after the handshake: `hready_out` is 1 and `hresp` is OKAY.
- R6: After a read handshake, `hready_out` stays 0 until `rsp_valid`. In the next cycle `hready_out` is 1 and `hrdata` equals the returned data. In every other cycle `hrdata` is 0.
- R7: A sampled NONSEQ/SEQ transfer with `hsize` 011 or above gets an ERROR. In the first cycle `hready_out` is 0 and `hresp` is 01. In the second cycle `hready_out` is 1 and `hresp` is 01. No request is created.
- R8: A sampled NONSEQ/SEQ transfer with more than one `hsel_cs` bit set, or with no bit set, gets the same two-cycle ERROR and no request.
- R9: Chip-select bits without `hsel_glb`, or any transfer while `hready_in` is 0, are ignored: no request, no ERROR, and `hready_out` stays 1.
- R10: `hresp` never takes the values 10 or 11.
- R11: `lock_out` is updated on every cycle with `hready_in` high to `hmastlock AND hsel_glb`, and it holds otherwise.
- R12: With every input tied to 0, the block stays in its reset state on its outputs indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsel_glb | input | 1 | Global select for this port |
| hsel_cs | input | 8 | One-hot chip-select lines |
| haddr | input | 29 | Address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write |
| hsize | input | 3 | Transfer size code |
| hburst | input | 3 | Burst code |
| hmastlock | input | 1 | Master lock request |
| hwdata | input | 32 | Write data (data phase) |
| hready_in | input | 1 | Bus ready, qualifies the address phase |
| hready_out | output | 1 | Slave ready, low to insert wait states |
| hresp | output | 2 | Response: 00 OKAY, 01 ERROR |
| hrdata | output | 32 | Read data |
| req_valid | output | 1 | Request valid toward the back end |
| req_ready | input | 1 | Back end takes the request |
| req_cs | output | 3 | Chip-select index |
| req_addr | output | 29 | Request address |
| req_size | output | 3 | Request size code |
| req_write | output | 1 | Request direction |
| req_burst | output | 3 | Request burst code |
| req_lock | output | 1 | Lock value at the address phase |
| req_wdata | output | 32 | Write data of the request |
| rsp_valid | input | 1 | Read data returned |
| rsp_rdata | input | 32 | Returned read data |
| lock_out | output | 1 | Lock level to the arbiter |

## Verification
A wrong control state shows up on `hready_out` in the very next cycle. A state stuck in a wait position freezes the bus, which the watchdog exposes. A state that wrongly reports ready ends a transfer before the back end has handshaken, which shows as `req_valid` still high next to a ready bus. A fault in the error path appears within two cycles, as a one-cycle ERROR or as an ERROR with `hready_out` high in its first cycle. A decode fault shows as a request whose chip-select index or fields differ from the address phase one cycle earlier.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

  typedef enum logic [2:0] {
    FS_OPEN   = 3'd0,
    FS_ISSUE  = 3'd1,
    FS_RDWAIT = 3'd2,
    FS_DONE   = 3'd3,
    FS_ERRA   = 3'd4,
    FS_ERRB   = 3'd5
  } fe_state_e;

  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] RESP_ERROR = 2'b01;

  localparam logic [2:0] SIZE_WORD  = 3'b010;

  function automatic int unsigned bit_count(input logic [7:0] v, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < n; i++) c += v[i] ? 1 : 0;
    return c;
  endfunction

endpackage

// File: rtl/mpf_decode.sv
module mpf_decode #(
  parameter int CS_N = 8,
  localparam int CS_W = $clog2(CS_N)
) (
  input  logic            hsel_glb,
  input  logic [CS_N-1:0] hsel_cs,
  input  logic [1:0]      htrans,
  input  logic [2:0]      hsize,
  input  logic            hready_in,
  input  logic            slot_open,
  output logic            take_ok,
  output logic            take_err,
  output logic [CS_W-1:0] cs_idx
);
  import mpf_pkg::*;

  logic       sampled;
  logic       active;
  logic       cs_single;
  logic       size_ok;
  logic [7:0] cs_wide;

  always_comb begin
    cs_wide = '0;
    cs_wide[CS_N-1:0] = hsel_cs;
  end

  assign sampled   = hsel_glb & hready_in & slot_open;
  assign active    = htrans[1];
  assign cs_single = (bit_count(cs_wide, CS_N) == 1);
  assign size_ok   = (hsize <= SIZE_WORD);

  assign take_ok  = sampled & active & cs_single & size_ok;
  assign take_err = sampled & active & ~(cs_single & size_ok);

  always_comb begin
    cs_idx = '0;
    for (int i = 0; i < CS_N; i++) begin
      if (hsel_cs[i]) cs_idx = CS_W'(i);
    end
  end

  always_comb begin
    AST_TAKE_EXCLUSIVE: assert (!(take_ok && take_err)); // R8
  end

endmodule

// File: rtl/mpf_ctrl.sv
module mpf_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take_ok,
  input  logic       take_err,
  input  logic       cur_write,
  input  logic       req_ready,
  input  logic       rsp_valid,
  input  logic       hready_in,
  input  logic       hsel_glb,
  input  logic       hmastlock,
  output logic       hready_out,
  output logic [1:0] hresp,
  output logic       req_valid,
  output logic       rd_capture,
  output logic       lock_out
);
  import mpf_pkg::*;

  fe_state_e st_q, st_d;
  logic      lock_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      FS_OPEN, FS_DONE, FS_ERRB: begin
        if (take_ok)       st_d = FS_ISSUE;
        else if (take_err) st_d = FS_ERRA;
        else               st_d = FS_OPEN;
      end
      FS_ISSUE:  if (req_ready) st_d = cur_write ? FS_DONE : FS_RDWAIT;
      FS_RDWAIT: if (rsp_valid) st_d = FS_DONE;
      FS_ERRA:   st_d = FS_ERRB;
      default:   st_d = FS_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FS_OPEN;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lock_q <= 1'b0;
    else if (hready_in) lock_q <= hmastlock & hsel_glb;
  end

  assign hready_out = (st_q == FS_OPEN) | (st_q == FS_DONE) | (st_q == FS_ERRB);
  assign hresp      = ((st_q == FS_ERRA) | (st_q == FS_ERRB)) ? RESP_ERROR : RESP_OKAY;
  assign req_valid  = (st_q == FS_ISSUE);
  assign rd_capture = (st_q == FS_RDWAIT) & rsp_valid;
  assign lock_out   = lock_q;

  AST_RESP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    hresp[1] == 1'b0); // R10

  AST_ERR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp == RESP_ERROR && !hready_out) |=> (hresp == RESP_ERROR && hready_out)); // R7

  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp == RESP_ERROR) |-> !req_valid); // R8

  AST_WAIT_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !hready_out); // R3

  AST_LOCK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_out) |-> $past(hmastlock)); // R11

endmodule

// File: rtl/mpf_reqreg.sv
module mpf_reqreg #(
  parameter int ADDR_W = 29,
  parameter int DATA_W = 32,
  parameter int CS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_ok,
  input  logic [CS_W-1:0]   cs_idx,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [2:0]        hsize,
  input  logic              hwrite,
  input  logic [2:0]        hburst,
  input  logic              hmastlock,
  input  logic              rd_capture,
  input  logic [DATA_W-1:0] rsp_rdata,
  input  logic              req_valid,
  input  logic              req_ready,
  output logic [CS_W-1:0]   req_cs,
  output logic [ADDR_W-1:0] req_addr,
  output logic [2:0]        req_size,
  output logic              req_write,
  output logic [2:0]        req_burst,
  output logic              req_lock,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_cs    <= '0;
      req_addr  <= '0;
      req_size  <= '0;
      req_write <= 1'b0;
      req_burst <= '0;
      req_lock  <= 1'b0;
    end else if (take_ok) begin
      req_cs    <= cs_idx;
      req_addr  <= haddr;
      req_size  <= hsize;
      req_write <= hwrite;
      req_burst <= hburst;
      req_lock  <= hmastlock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata_q <= '0;
    else if (rd_capture) rdata_q <= rsp_rdata;
    else                 rdata_q <= '0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_cs)
      && $stable(req_size) && $stable(req_write) && $stable(req_burst))); // R4

endmodule

// File: rtl/mem_port_front.sv
module mem_port_front #(
  parameter int ADDR_W = 29,
  parameter int DATA_W = 32,
  parameter int CS_N   = 8,
  localparam int CS_W  = $clog2(CS_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel_glb,
  input  logic [CS_N-1:0]   hsel_cs,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [2:0]        hburst,
  input  logic              hmastlock,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              hready_in,
  output logic              hready_out,
  output logic [1:0]        hresp,
  output logic [DATA_W-1:0] hrdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [CS_W-1:0]   req_cs,
  output logic [ADDR_W-1:0] req_addr,
  output logic [2:0]        req_size,
  output logic              req_write,
  output logic [2:0]        req_burst,
  output logic              req_lock,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              lock_out
);

  logic            take_ok;
  logic            take_err;
  logic [CS_W-1:0] cs_idx;
  logic            rd_capture;

  mpf_decode #(.CS_N(CS_N)) u_decode (
    .hsel_glb  (hsel_glb),
    .hsel_cs   (hsel_cs),
    .htrans    (htrans),
    .hsize     (hsize),
    .hready_in (hready_in),
    .slot_open (hready_out),
    .take_ok   (take_ok),
    .take_err  (take_err),
    .cs_idx    (cs_idx)
  );

  mpf_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_ok    (take_ok),
    .take_err   (take_err),
    .cur_write  (req_write),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .hready_in  (hready_in),
    .hsel_glb   (hsel_glb),
    .hmastlock  (hmastlock),
    .hready_out (hready_out),
    .hresp      (hresp),
    .req_valid  (req_valid),
    .rd_capture (rd_capture),
    .lock_out   (lock_out)
  );

  mpf_reqreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_W(CS_W)) u_reqreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_ok    (take_ok),
    .cs_idx     (cs_idx),
    .haddr      (haddr),
    .hsize      (hsize),
    .hwrite     (hwrite),
    .hburst     (hburst),
    .hmastlock  (hmastlock),
    .rd_capture (rd_capture),
    .rsp_rdata  (rsp_rdata),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_cs     (req_cs),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_write  (req_write),
    .req_burst  (req_burst),
    .req_lock   (req_lock),
    .rdata_q    (hrdata)
  );

  assign req_wdata = req_valid ? hwdata : '0;

  AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hready_in) && $past(hready_out) && !$past(hsel_glb)) |-> (!req_valid && hresp == 2'b00)); // R12

  AST_RDATA_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !hready_out |-> (hrdata == '0)); // R6

endmodule

// File: tb/mem_port_front_tb.sv
module mem_port_front_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsel_glb = 1'b0;
  logic [7:0]  hsel_cs = '0;
  logic [28:0] haddr = '0;
  logic [1:0]  htrans = '0;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = '0;
  logic [2:0]  hburst = '0;
  logic        hmastlock = 1'b0;
  logic [31:0] hwdata = '0;
  logic        rdy_mask = 1'b1;
  logic        hready_in;
  logic        hready_out;
  logic [1:0]  hresp;
  logic [31:0] hrdata;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [2:0]  req_cs;
  logic [28:0] req_addr;
  logic [2:0]  req_size;
  logic        req_write;
  logic [2:0]  req_burst;
  logic        req_lock;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;
  logic        lock_out;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  assign hready_in = hready_out & rdy_mask;

  mem_port_front u_dut (
    .clk(clk), .rst_n(rst_n), .hsel_glb(hsel_glb), .hsel_cs(hsel_cs), .haddr(haddr),
    .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hmastlock(hmastlock),
    .hwdata(hwdata), .hready_in(hready_in), .hready_out(hready_out), .hresp(hresp),
    .hrdata(hrdata), .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write), .req_burst(req_burst),
    .req_lock(req_lock), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .lock_out(lock_out)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_idle();
    hsel_glb = 0; hsel_cs = 0; htrans = 0; hwrite = 0; hsize = 0; hburst = 0; hmastlock = 0;
  endtask

  task automatic addr_phase(input logic [7:0] cs, input logic [28:0] a, input logic [1:0] tr,
                            input logic wr, input logic [2:0] sz, input logic [2:0] bu);
    hsel_glb = 1; hsel_cs = cs; haddr = a; htrans = tr; hwrite = wr; hsize = sz; hburst = bu;
  endtask

  task automatic t_reset();
    chk(hready_out == 1, "R1 ready", hready_out, 1);
    chk(hresp == 0, "R1 resp", hresp, 0);
    chk(req_valid == 0, "R1 req_valid", req_valid, 0);
    chk(lock_out == 0, "R1 lock", lock_out, 0);
    chk(hrdata == 0, "R1 rdata", hrdata, 0);
  endtask

  task automatic t_idle_busy();
    addr_phase(8'h04, 29'h100, 2'b00, 0, 3'b010, 0);
    step();
    chk(hready_out == 1 && hresp == 0, "R2 idle okay", {hready_out, hresp}, 3'b100);
    chk(req_valid == 0, "R2 idle no req", req_valid, 0);
    htrans = 2'b01;
    step();
    chk(hready_out == 1 && hresp == 0 && req_valid == 0, "R2 busy", {req_valid, hready_out, hresp}, 4'b0100);
    bus_idle();
    step();
  endtask

  task automatic t_write();
    addr_phase(8'h20, 29'h0ABC_DE0, 2'b10, 1, 3'b001, 3'b000);
    hmastlock = 1;
    step();
    bus_idle();
    hwdata = 32'hCAFE_F00D;
    chk(req_valid == 1 && hready_out == 0, "R3 write issued", {req_valid, hready_out}, 2'b10);
    chk(req_cs == 3'd5, "R3 cs index", req_cs, 5);
    chk(req_addr == 29'h0ABC_DE0, "R3 addr", req_addr, 29'h0ABC_DE0);
    chk(req_size == 3'b001 && req_write == 1 && req_lock == 1, "R3 fields",
        {req_size, req_write, req_lock}, {3'b001, 1'b1, 1'b1});
    step();
    step();
    chk(req_valid == 1 && req_addr == 29'h0ABC_DE0 && hready_out == 0, "R4 hold", {req_valid, hready_out}, 2'b10);
    chk(req_wdata == 32'hCAFE_F00D, "R4 wdata", req_wdata, 32'hCAFE_F00D);
    req_ready = 1;
    step();
    req_ready = 0;
    chk(hready_out == 1 && hresp == 0 && req_valid == 0, "R5 write done", {req_valid, hready_out, hresp}, 4'b0100);
    step();
  endtask

  task automatic t_read();
    addr_phase(8'h01, 29'h1234, 2'b10, 0, 3'b010, 3'b011);
    step();
    bus_idle();
    chk(req_valid == 1 && req_write == 0 && req_cs == 0 && req_burst == 3'b011, "R3 read issued",
        {req_valid, req_write, req_cs, req_burst}, {1'b1, 1'b0, 3'd0, 3'b011});
    req_ready = 1;
    step();
    req_ready = 0;
    chk(req_valid == 0 && hready_out == 0 && hrdata == 0, "R6 waiting", {req_valid, hready_out}, 2'b00);
    rsp_valid = 1; rsp_rdata = 32'h1357_9BDF;
    step();
    rsp_valid = 0; rsp_rdata = 32'hFFFF_FFFF;
    chk(hready_out == 1 && hrdata == 32'h1357_9BDF, "R6 read data", hrdata, 32'h1357_9BDF);
    step();
    chk(hrdata == 0, "R6 rdata cleared", hrdata, 0);
  endtask

  task automatic t_burst_seq();
    addr_phase(8'h80, 29'h40, 2'b11, 1, 3'b000, 3'b110);
    step();
    bus_idle();
    chk(req_valid == 1 && req_cs == 7 && req_burst == 3'b110 && req_size == 0, "R3 seq wrap16",
        {req_cs, req_burst, req_size}, {3'd7, 3'b110, 3'd0});
    req_ready = 1;
    step();
    req_ready = 0;
    step();
  endtask

  task automatic err_expect(input string tag);
    step();
    bus_idle();
    chk(hready_out == 0 && hresp == 2'b01 && req_valid == 0, {tag, " first"}, {req_valid, hready_out, hresp}, 4'b0001);
    step();
    chk(hready_out == 1 && hresp == 2'b01, {tag, " second"}, {hready_out, hresp}, 3'b101);
    step();
    chk(hresp == 0 && req_valid == 0, {tag, " after"}, {req_valid, hresp}, 3'b000);
  endtask

  task automatic t_size_err();
    addr_phase(8'h02, 29'h8, 2'b10, 0, 3'b011, 0);
    err_expect("R7 size64");
    addr_phase(8'h02, 29'h8, 2'b10, 1, 3'b111, 0);
    err_expect("R7 size1024");
  endtask

  task automatic t_cs_err();
    addr_phase(8'h06, 29'h8, 2'b10, 0, 3'b010, 0);
    err_expect("R8 multi cs");
    addr_phase(8'h00, 29'h8, 2'b11, 0, 3'b010, 0);
    err_expect("R8 no cs");
  endtask

  task automatic t_ignored();
    addr_phase(8'h10, 29'h55, 2'b10, 1, 3'b010, 0);
    hsel_glb = 0;
    step();
    chk(req_valid == 0 && hready_out == 1 && hresp == 0, "R9 no global", {req_valid, hready_out, hresp}, 4'b0100);
    hsel_glb = 1;
    rdy_mask = 0;
    step();
    rdy_mask = 1;
    bus_idle();
    chk(req_valid == 0 && hready_out == 1 && hresp == 0, "R9 hready_in low", {req_valid, hready_out, hresp}, 4'b0100);
    step();
  endtask

  task automatic t_lock();
    hsel_glb = 1; hmastlock = 1;
    step();
    chk(lock_out == 1, "R11 lock set", lock_out, 1);
    rdy_mask = 0; hmastlock = 0;
    step();
    chk(lock_out == 1, "R11 lock held", lock_out, 1);
    rdy_mask = 1;
    step();
    chk(lock_out == 0, "R11 lock clear", lock_out, 0);
    hsel_glb = 0; hmastlock = 1;
    step();
    chk(lock_out == 0, "R11 lock needs global", lock_out, 0);
    bus_idle();
    step();
  endtask

  task automatic t_zero_port();
    bus_idle(); haddr = 0; hwdata = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      chk(req_valid == 0 && hready_out == 1 && hresp == 0 && lock_out == 0 && hrdata == 0,
          "R12 tied low", {req_valid, hready_out, hresp, lock_out}, 5'b01000);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1;
    step();
    t_idle_busy();
    t_write();
    t_read();
    t_burst_seq();
    t_size_err();
    t_cs_err();
    t_ignored();
    t_lock();
    t_zero_port();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule